// File: doc/BRIEF.md
# Key-protected debug halt control register

This block is a single 32-bit memory-mapped control and status register through which an external debugger halts, resumes and single-steps a processor core. Writes arrive on a simple one-cycle write strobe with a source flag that separates debugger accesses from accesses made by software running on the core. A write takes effect only if its upper halfword carries an unlock key. The low four bits hold the control state. The upper half reports live core status and two sticky event flags.

The control state drives a core-control stub through four outputs: a halt request, a one-cycle resume pulse, a step-mode level and an interrupt-mask level. All four are forced inactive while debug is disabled. The debug enable bit only changes on debugger writes. While the core is running with debug enabled, the step and mask bits are frozen against writes. The instruction-retired and reset-occurred flags catch pulses from the core and are cleared by a read. The read value is combinational from the register state and the status inputs, and a read strobe clears the sticky flags at the following clock edge.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write whose data bits [31:16] differ from the key (default 0xA05F) changes no register state and produces no output effect.
- R2: Read layout: bit 0 debug enable, bit 1 halt, bit 2 step, bit 3 interrupt mask, bit 16 register-transfer ready, bit 17 halted, bit 18 sleeping, bit 19 locked up, bit 24 instruction retired, bit 25 reset occurred. All other bits read 0.
- R3: After reset, with all status inputs low, the read value is 0x02000000 and every control output is low.
- R4: Bit 0 is written only when src_dbg_i=1. A keyed write with src_dbg_i=0 keeps the enable bit but still updates the halt bit, and the step and mask bits subject to R10.
- R5: While the enable bit is 0, halt_req_o, step_o, mask_int_o and resume_o are all 0, whatever the other control bits hold.
- R6: A keyed write with bit 1 = 1 that leaves debug enabled while core_halted_i=0 raises halt_req_o from the next cycle. The output stays high until core_halted_i is 1, and is 0 in the cycle after that.
- R7: A keyed write with bit 1 = 0 that leaves debug enabled while core_halted_i=1 gives resume_o high for exactly the next cycle. resume_o is never high otherwise.
- R8: step_o equals enable AND the step bit, and mask_int_o equals enable AND the mask bit, so a step-mode resume is issued as one resume_o pulse.
- R9: Read bits 16 to 19 follow core_regrdy_i, core_halted_i, core_sleep_i and core_lockup_i in the same cycle, so bit 17 reads 0 while the core runs.
- R10: While the enable bit is 1 and core_halted_i=0, writes leave the step and mask bits unchanged. The halt bit still updates.
- R11: Bits 24 and 25 are set by core_retire_i and core_reset_i pulses and cleared at the edge ending a cycle with rd_en_i=1. A pulse in the same cycle as a read leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe; clears sticky flags |
| src_dbg_i | input | 1 | 1 = access from debugger, 0 = from core software |
| wdata_i | input | 32 | Write data, key in [31:16] |
| rdata_o | output | 32 | Read value |
| core_halted_i | input | 1 | Core is halted |
| core_sleep_i | input | 1 | Core is sleeping |
| core_lockup_i | input | 1 | Core is locked up |
| core_regrdy_i | input | 1 | Register transfer complete |
| core_retire_i | input | 1 | Pulse: instruction retired |
| core_reset_i | input | 1 | Pulse: core reset occurred |
| halt_req_o | output | 1 | Halt request to core |
| resume_o | output | 1 | One-cycle request to run a halted core |
| step_o | output | 1 | Single-step mode active |
| mask_int_o | output | 1 | Mask interrupts while debugging |

## Verification
The bench builds the block with its default key of 0xA05F. This lets it send writes with the correct key, writes with one wrong nibble, and debugger and core-software writes at the exact values used by the reference model. It steps the core status inputs through running, halted and stepped phases. This exercises the halt-request hold and drop, the frozen step and mask bits, and the resume pulse. It also lands retire and reset pulses on the same cycle as reads, which checks that a set takes priority over a clear.

// File: rtl/dbg_hc_pkg.sv
package dbg_hc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned KEY_LSB  = 16;
  localparam logic [15:0] KEY_DEF  = 16'hA05F;
  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_HALT   = 1;
  localparam int unsigned B_STEP   = 2;
  localparam int unsigned B_MASK   = 3;
  localparam int unsigned B_REGRDY = 16;
  localparam int unsigned B_HALTED = 17;
  localparam int unsigned B_SLEEP  = 18;
  localparam int unsigned B_LOCKUP = 19;
  localparam int unsigned B_RETIRE = 24;
  localparam int unsigned B_RSTEV  = 25;
  localparam int unsigned N_STICKY = 2;   // index 0 retire, index 1 reset event

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dbg_hc_wrfilt.sv
module dbg_hc_wrfilt
  import dbg_hc_pkg::*;
#(
  parameter logic [15:0] KEY = KEY_DEF
) (
  input  logic              wr_en_i,
  input  logic              src_dbg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ctrl_t             ctrl_i,
  input  logic              core_halted_i,
  output logic              accept_o,
  output ctrl_t             ctrl_o
);
  logic locked;

  assign accept_o = wr_en_i && (wdata_i[DATA_W-1:KEY_LSB] == KEY);
  // step/mask frozen while debugging a running core
  assign locked   = ctrl_i.en && !core_halted_i;

  always_comb begin
    ctrl_o = ctrl_i;
    if (accept_o) begin
      if (src_dbg_i) ctrl_o.en = wdata_i[B_EN];
      ctrl_o.halt = wdata_i[B_HALT];
      if (!locked) begin
        ctrl_o.step = wdata_i[B_STEP];
        ctrl_o.mask = wdata_i[B_MASK];
      end
    end
  end
endmodule

// File: rtl/dbg_hc_run.sv
module dbg_hc_run (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic wr_halt_i,
  input  logic en_nxt_i,
  input  logic core_halted_i,
  output logic pend_o,
  output logic resume_o
);
  logic pend_d, resume_d;

  always_comb begin
    if (!en_nxt_i || core_halted_i) pend_d = 1'b0;
    else if (accept_i)              pend_d = wr_halt_i;
    else                            pend_d = pend_o;
    resume_d = accept_i && en_nxt_i && !wr_halt_i && core_halted_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o   <= 1'b0;
      resume_o <= 1'b0;
    end else begin
      pend_o   <= pend_d;
      resume_o <= resume_d;
    end
  end
endmodule

// File: rtl/dbg_hc_sticky.sv
module dbg_hc_sticky #(
  parameter int unsigned     N       = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= RST_VAL[i];
      else if (set_i[i]) q_o[i] <= 1'b1;   // set beats clear
      else if (clr_i)    q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_hc_pkg::*;
#(
  parameter logic [15:0] KEY = KEY_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              src_dbg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              core_halted_i,
  input  logic              core_sleep_i,
  input  logic              core_lockup_i,
  input  logic              core_regrdy_i,
  input  logic              core_retire_i,
  input  logic              core_reset_i,
  output logic              halt_req_o,
  output logic              resume_o,
  output logic              step_o,
  output logic              mask_int_o
);
  ctrl_t               ctrl_q, ctrl_d;
  logic                accept, pend;
  logic [N_STICKY-1:0] sticky;

  dbg_hc_wrfilt #(.KEY(KEY)) u_wrfilt (
    .wr_en_i      (wr_en_i),
    .src_dbg_i    (src_dbg_i),
    .wdata_i      (wdata_i),
    .ctrl_i       (ctrl_q),
    .core_halted_i(core_halted_i),
    .accept_o     (accept),
    .ctrl_o       (ctrl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  dbg_hc_run u_run (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .wr_halt_i    (wdata_i[B_HALT]),
    .en_nxt_i     (ctrl_d.en),
    .core_halted_i(core_halted_i),
    .pend_o       (pend),
    .resume_o     (resume_o)
  );

  dbg_hc_sticky #(.N(N_STICKY), .RST_VAL(2'b10)) u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i ({core_reset_i, core_retire_i}),
    .clr_i (rd_en_i),
    .q_o   (sticky)
  );

  always_comb begin
    rdata_o           = '0;
    rdata_o[B_EN]     = ctrl_q.en;
    rdata_o[B_HALT]   = ctrl_q.halt;
    rdata_o[B_STEP]   = ctrl_q.step;
    rdata_o[B_MASK]   = ctrl_q.mask;
    rdata_o[B_REGRDY] = core_regrdy_i;
    rdata_o[B_HALTED] = core_halted_i;
    rdata_o[B_SLEEP]  = core_sleep_i;
    rdata_o[B_LOCKUP] = core_lockup_i;
    rdata_o[B_RETIRE] = sticky[0];
    rdata_o[B_RSTEV]  = sticky[1];
  end

  assign halt_req_o = ctrl_q.en && pend;
  assign step_o     = ctrl_q.en && ctrl_q.step;
  assign mask_int_o = ctrl_q.en && ctrl_q.mask;
endmodule

// File: rtl/dbg_hc_chk.sv
module dbg_hc_chk #(
  parameter logic [15:0] KEY = 16'hA05F
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        src_dbg_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        core_halted_i,
  input logic        core_retire_i,
  input logic        core_reset_i,
  input logic        halt_req_o,
  input logic        resume_o,
  input logic        step_o,
  input logic        mask_int_o
);
  a_r1_bad_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[31:16] != KEY) |=> (rdata_o[3:0] == $past(rdata_o[3:0])));

  a_r4_core_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !src_dbg_i) |=> (rdata_o[0] == $past(rdata_o[0])));

  a_r5_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[0] |-> (!halt_req_o && !step_o && !mask_int_o && !resume_o));

  a_r6_halt_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_halted_i |=> !halt_req_o);

  a_r7_resume_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> $past(wr_en_i && wdata_i[31:16] == KEY && !wdata_i[1] && core_halted_i));

  a_r10_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rdata_o[0] && !core_halted_i) |=> (rdata_o[3:2] == $past(rdata_o[3:2])));

  a_r11_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_retire_i || core_reset_i) |=>
      ((rdata_o[24] || !$past(core_retire_i)) && (rdata_o[25] || !$past(core_reset_i))));

  a_r2_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[15:4] == '0) && (rdata_o[23:20] == '0) && (rdata_o[31:26] == '0));
endmodule

bind dbg_halt_ctrl dbg_hc_chk #(.KEY(KEY)) u_chk (.*);

// File: tb/dbg_halt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_test;
  logic        clk = 0, rst_ni = 0;
  logic        wr = 0, rd = 0, src = 0;
  logic [31:0] wd = '0, rdata;
  logic        halted = 0, sleep = 0, lockup = 0, regrdy = 0, retire = 0, rstev = 0;
  logic        halt_req, resume, step, mask;

  int checks = 0, failures = 0, cyc_cnt = 0;
  string cur = "R3";

  // reference model state
  bit m_en, m_h, m_s, m_m, m_pend, m_res, m_ret, m_rst;

  always #2 clk = ~clk;

  dbg_halt_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr), .rd_en_i(rd), .src_dbg_i(src),
    .wdata_i(wd), .rdata_o(rdata), .core_halted_i(halted), .core_sleep_i(sleep),
    .core_lockup_i(lockup), .core_regrdy_i(regrdy), .core_retire_i(retire),
    .core_reset_i(rstev), .halt_req_o(halt_req), .resume_o(resume),
    .step_o(step), .mask_int_o(mask)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", cur, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    logic [31:0] v = '0;
    v[0] = m_en; v[1] = m_h; v[2] = m_s; v[3] = m_m;
    v[16] = regrdy; v[17] = halted; v[18] = sleep; v[19] = lockup;
    v[24] = m_ret; v[25] = m_rst;
    return v;
  endfunction

  task automatic compare();
    chk("rdata", rdata, m_rdata());
    chk("halt_req", {31'b0, halt_req}, {31'b0, m_en & m_pend});
    chk("step", {31'b0, step}, {31'b0, m_en & m_s});
    chk("mask", {31'b0, mask}, {31'b0, m_en & m_m});
    chk("resume", {31'b0, resume}, {31'b0, m_res});
  endtask

  task automatic model_edge();
    bit acc, en_n, lock;
    acc  = wr && wd[31:16] == 16'hA05F;
    lock = m_en && !halted;
    en_n = (acc && src) ? wd[0] : m_en;
    m_res  = acc && en_n && !wd[1] && halted;
    m_pend = (en_n && !halted) ? (acc ? wd[1] : m_pend) : 1'b0;
    if (acc) begin
      m_h = wd[1];
      if (!lock) begin m_s = wd[2]; m_m = wd[3]; end
    end
    m_en  = en_n;
    m_ret = retire | (m_ret & ~rd);
    m_rst = rstev  | (m_rst & ~rd);
  endtask

  // one clock: drive at negedge, model at posedge, compare just after
  task automatic cyc(bit w, bit r, bit s, logic [31:0] d);
    @(negedge clk);
    wr = w; rd = r; src = s; wd = d;
    @(posedge clk);
    model_edge();
    #1 compare();
    @(negedge clk);
    wr = 0; rd = 0; retire = 0; rstev = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    m_en = 0; m_h = 0; m_s = 0; m_m = 0; m_pend = 0; m_res = 0; m_ret = 0; m_rst = 1;
    #5;
    cur = "R3"; compare();                         // reset value 0x02000000
    chk("reset value", rdata, 32'h0200_0000);
    @(negedge clk); rst_ni = 1;
    idle(2);

    cur = "R11"; cyc(0, 1, 0, '0);                 // read clears reset flag
    chk("rstev cleared", {31'b0, rdata[25]}, 32'd0);

    cur = "R1"; cyc(1, 0, 1, 32'hA05E_000F);       // wrong key
    chk("bad key ignored", rdata[3:0], 4'h0);

    cur = "R4"; cyc(1, 0, 0, 32'hA05F_000F);       // core write: en stays 0
    chk("core en blocked", {31'b0, rdata[0]}, 32'd0);
    cur = "R5"; chk("gated off", {28'b0, halt_req, step, mask, resume}, 32'd0);
    idle(1);

    cur = "R6"; cyc(1, 0, 1, 32'hA05F_0003);       // enable + halt, core running
    chk("halt_req set", {31'b0, halt_req}, 32'd1);
    idle(3);
    halted = 1; cyc(0, 0, 0, '0);
    chk("halt_req cleared", {31'b0, halt_req}, 32'd0);

    cur = "R9"; regrdy = 1; sleep = 1; lockup = 1; idle(1);
    chk("live status", {12'b0, rdata[19:16]}, 16'h000F);
    regrdy = 0; sleep = 0; lockup = 0;

    cur = "R7"; cyc(1, 0, 1, 32'hA05F_0005);       // step, resume
    chk("resume pulse", {31'b0, resume}, 32'd1);
    cur = "R8"; chk("step out", {31'b0, step}, 32'd1);
    halted = 0; retire = 1; cyc(0, 0, 0, '0);
    cur = "R7"; chk("resume one cycle", {31'b0, resume}, 32'd0);
    cur = "R9"; chk("halted reads 0", {31'b0, rdata[17]}, 32'd0);
    halted = 1; idle(1);

    cur = "R10"; halted = 0; cyc(1, 0, 1, 32'hA05F_000B);  // running: step/mask frozen
    chk("lock step/mask", rdata[3:0], 4'h7);
    halted = 1; cyc(1, 0, 0, 32'hA05F_0008);       // halted core write: mask on, step off
    cur = "R8"; chk("mask out", {30'b0, mask, step}, 32'd2);
    cur = "R4"; chk("core keeps en", {31'b0, rdata[0]}, 32'd1);

    cur = "R11"; retire = 1; rstev = 1; cyc(0, 1, 0, '0);  // set beats clear
    chk("sticky set wins", {30'b0, rdata[25:24]}, 32'd3);
    cyc(0, 1, 0, '0);
    chk("sticky cleared", {30'b0, rdata[25:24]}, 32'd0);

    cur = "R5"; cyc(1, 0, 1, 32'hA05F_000E);       // disable, others set
    chk("disabled outputs", {28'b0, halt_req, step, mask, resume}, 32'd0);
    halted = 0; cyc(1, 0, 1, 32'hA05F_0002);
    chk("halt gated", {31'b0, halt_req}, 32'd0);
    cur = "R2"; chk("layout", rdata, 32'h0000_0002);
    idle(2);
    finish_run();
  end
endmodule